// File: doc/BRIEF.md
# Bit-split parallel string matcher

This block scans a byte stream for a set of up to sixteen patterns. It uses several identical finite-state tiles. Every tile sees only its own two-bit slice of each incoming byte, and all tiles take one deterministic transition together each time a byte is presented. Failure transitions are already folded into each tile's next-state table, so every state has exactly one successor for every slice value, and every tile starts in state 0.

Each tile keeps three separate stores:
- a next-state table,
- a per-state index,
- a small table of partial match vectors that states share.

The index value 0 stands for an all-zero vector and causes no table read. States that imply no match therefore cost no table entry.

The partial vectors of the states all tiles have just entered are ANDed into a full match vector. That vector is registered with a valid flag. All tables are written through a simple configuration port before the stream is applied. How the table contents are produced is outside this block.

Top module: `smx_bitsplit_matcher`

## Requirements
- R1: Reset returns every tile to state 0 and clears `hit_valid` and `hit_vec`. Reset leaves the table contents unchanged.
- R2: Tile t uses byte bits [2t+1:2t] as its slice. On a clock edge with `sym_valid`=1, each tile moves to the state its next-state table holds at address {state, slice}.
- R3: `hit_vec` is the bitwise AND, over all tiles, of the partial vector selected by the index of the state that tile has just entered. States that share an index yield the same vector.
- R4: An index of 0 yields an all-zero partial vector. A write to vector-table entry 0 has no effect on any result.
- R5: The result for a byte appears on the clock edge that consumes the byte, and is visible in the following cycle. `hit_valid` is 1 exactly when `hit_vec` has at least one bit set.
- R6: On a clock edge with `sym_valid`=0, every tile keeps its state, and `hit_valid` and `hit_vec` become 0.
- R7: A write takes effect when `cfg_we`=1, and goes to the tile numbered `cfg_tile`.
  - `cfg_sel`=0 writes the next-state table at `cfg_addr`={state[5:0], slice[1:0]} with `cfg_data[5:0]`.
  - `cfg_sel`=1 writes the index of state `cfg_addr[5:0]` with `cfg_data[3:0]`.
  - `cfg_sel`=2 writes vector entry `cfg_addr[3:0]` with `cfg_data[15:0]`.
  - `cfg_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Table select: 0 next-state, 1 index, 2 vector, 3 none |
| cfg_tile | input | 2 | Target tile number |
| cfg_addr | input | 8 | Table address |
| cfg_data | input | 16 | Write data |
| sym_valid | input | 1 | Byte present this cycle |
| sym_in | input | 8 | Input byte |
| hit_valid | output | 1 | Full match vector is non-zero |
| hit_vec | output | 16 | Registered full match vector |

## Verification
Every byte result and every idle-cycle result is due one register stage after the edge that takes the byte. The bench therefore drives each byte at a falling edge and compares outputs 1 ns after the next rising edge against a behavioural model. That model walks its own copy of the tables, using integer arrays. A configuration write lands on the edge that samples it, and streaming only starts after loading has finished. A reset mid-stream is checked first for cleared outputs, and then for a restart from state 0 with the tables still intact.

// File: rtl/smx_pkg.sv
package smx_pkg;
  localparam int SYM_W    = 8;
  localparam int SLICE_W  = 2;
  localparam int N_STATES = 64;
  localparam int N_PAT    = 16;
  localparam int N_VEC    = 16;

  typedef enum logic [1:0] {
    CFG_NEXT   = 2'd0,
    CFG_INDEX  = 2'd1,
    CFG_VECTOR = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/smx_tile.sv
module smx_tile #(
  parameter int SLICE_W  = 2,
  parameter int N_STATES = 64,
  parameter int N_PAT    = 16,
  parameter int N_VEC    = 16,
  localparam int ST_W    = $clog2(N_STATES),
  localparam int IDX_W   = $clog2(N_VEC),
  localparam int AW      = ST_W + SLICE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_next,
  input  logic               wr_index,
  input  logic               wr_vector,
  input  logic [AW-1:0]      wr_addr,
  input  logic [N_PAT-1:0]   wr_data,
  input  logic               step,
  input  logic [SLICE_W-1:0] slice,
  output logic [N_PAT-1:0]   pmv_nx,
  output logic               table_read
);
  localparam int FAN   = 1 << SLICE_W;
  localparam int NXT_D = N_STATES * FAN;

  logic [ST_W-1:0]  next_mem [NXT_D];
  logic [IDX_W-1:0] idx_mem  [N_STATES];
  logic [N_PAT-1:0] vec_mem  [N_VEC];

  logic [ST_W-1:0]  state_q;
  logic [ST_W-1:0]  state_nx;
  logic [IDX_W-1:0] idx_nx;
  logic             vec_wr_ok;

  function automatic logic [AW-1:0] trans_addr(input logic [ST_W-1:0] s,
                                               input logic [SLICE_W-1:0] v);
    return {s, v};
  endfunction

  assign vec_wr_ok = wr_vector && (wr_addr[IDX_W-1:0] != '0);

  always_ff @(posedge clk) begin
    if (wr_next)   next_mem[wr_addr]          <= wr_data[ST_W-1:0];
    if (wr_index)  idx_mem[wr_addr[ST_W-1:0]] <= wr_data[IDX_W-1:0];
    if (vec_wr_ok) vec_mem[wr_addr[IDX_W-1:0]] <= wr_data;
  end

  assign state_nx   = next_mem[trans_addr(state_q, slice)];
  assign idx_nx     = idx_mem[state_nx];
  assign table_read = (idx_nx != '0);
  assign pmv_nx     = table_read ? vec_mem[idx_nx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= '0;
    else if (step) state_q <= state_nx;
  end

  // R6: an idle cycle leaves the tile state untouched
  p_state_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q));

  // R1: the first cycle out of reset starts from state 0
  p_start_state_r1: assert property (@(posedge clk)
    !rst_n |=> state_q == '0);
endmodule

// File: rtl/smx_match_combine.sv
module smx_match_combine #(
  parameter int N_TILES = 4,
  parameter int N_PAT   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step,
  input  logic [N_TILES-1:0][N_PAT-1:0] pmv_all,
  output logic                          hit_valid,
  output logic [N_PAT-1:0]              hit_vec
);
  logic [N_PAT-1:0] full_vec;

  function automatic logic [N_PAT-1:0] and_tiles(
      input logic [N_TILES-1:0][N_PAT-1:0] v);
    logic [N_PAT-1:0] acc;
    acc = '1;
    for (int t = 0; t < N_TILES; t++) acc = acc & v[t];
    return acc;
  endfunction

  assign full_vec = and_tiles(pmv_all);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_vec   <= '0;
      hit_valid <= 1'b0;
    end else if (step) begin
      hit_vec   <= full_vec;
      hit_valid <= |full_vec;
    end else begin
      hit_vec   <= '0;
      hit_valid <= 1'b0;
    end
  end

  // R3: a reported bit is present in every tile's partial vector
  for (genvar t = 0; t < N_TILES; t++) begin : g_sub
    p_hit_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (hit_vec & ~$past(pmv_all[t])) == '0);
  end

  // R5: the valid flag tracks a non-empty vector
  p_valid_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid == (hit_vec != '0));

  // R6: idle cycles report nothing
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> (!hit_valid && hit_vec == '0));
endmodule

// File: rtl/smx_bitsplit_matcher.sv
module smx_bitsplit_matcher
  import smx_pkg::*;
#(
  parameter int P_SYM_W    = SYM_W,
  parameter int P_SLICE_W  = SLICE_W,
  parameter int P_N_STATES = N_STATES,
  parameter int P_N_PAT    = N_PAT,
  parameter int P_N_VEC    = N_VEC,
  localparam int NT        = P_SYM_W / P_SLICE_W,
  localparam int TSEL_W    = (NT > 1) ? $clog2(NT) : 1,
  localparam int CFG_AW    = $clog2(P_N_STATES) + P_SLICE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [TSEL_W-1:0]  cfg_tile,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [P_N_PAT-1:0] cfg_data,
  input  logic               sym_valid,
  input  logic [P_SYM_W-1:0] sym_in,
  output logic               hit_valid,
  output logic [P_N_PAT-1:0] hit_vec
);
  logic [NT-1:0][P_N_PAT-1:0] pmv_all;
  logic [NT-1:0]              table_read_w;

  for (genvar t = 0; t < NT; t++) begin : g_tile
    logic tile_sel;
    assign tile_sel = cfg_we && (cfg_tile == TSEL_W'(t));

    smx_tile #(
      .SLICE_W (P_SLICE_W),
      .N_STATES(P_N_STATES),
      .N_PAT   (P_N_PAT),
      .N_VEC   (P_N_VEC)
    ) u_tile (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_next   (tile_sel && (cfg_sel == CFG_NEXT)),
      .wr_index  (tile_sel && (cfg_sel == CFG_INDEX)),
      .wr_vector (tile_sel && (cfg_sel == CFG_VECTOR)),
      .wr_addr   (cfg_addr),
      .wr_data   (cfg_data),
      .step      (sym_valid),
      .slice     (sym_in[t*P_SLICE_W +: P_SLICE_W]),
      .pmv_nx    (pmv_all[t]),
      .table_read(table_read_w[t])
    );

    // R4: a tile entering an index-0 state forces an empty result
    p_zero_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && !table_read_w[t]) |=> (hit_vec == '0 && !hit_valid));
  end

  smx_match_combine #(
    .N_TILES(NT),
    .N_PAT  (P_N_PAT)
  ) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (sym_valid),
    .pmv_all  (pmv_all),
    .hit_valid(hit_valid),
    .hit_vec  (hit_vec)
  );
endmodule

// File: tb/smx_bitsplit_matcher_tb.sv
module smx_bitsplit_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [1:0]  cfg_tile = 2'd0;
  logic [7:0]  cfg_addr = 8'd0;
  logic [15:0] cfg_data = 16'd0;
  logic        sym_valid = 1'b0;
  logic [7:0]  sym_in = 8'd0;
  logic        hit_valid;
  logic [15:0] hit_vec;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  int nxt [4][64][4];
  int ix  [4][64];
  int vec [4][16];
  int st  [4];
  int exp_vec;
  bit exp_v;

  always #5 clk = ~clk;

  smx_bitsplit_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_tile(cfg_tile), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .sym_valid(sym_valid), .sym_in(sym_in),
    .hit_valid(hit_valid), .hit_vec(hit_vec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic cfg_write(input int sel, input int tile, input int addr, input int data);
    @(negedge clk);
    sym_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_tile = 2'(tile);
    cfg_addr = 8'(addr); cfg_data = 16'(data);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Model: walk each tile's own table, AND the selected vectors
  task automatic send(input bit v, input int b, input string tag);
    int acc;
    @(negedge clk);
    sym_valid = v; sym_in = 8'(b);
    @(posedge clk); #1;
    if (v) begin
      acc = 16'hFFFF;
      for (int t = 0; t < 4; t++) begin
        st[t] = nxt[t][st[t]][(b >> (2*t)) & 3];
        acc = acc & ((ix[t][st[t]] == 0) ? 0 : vec[t][ix[t][st[t]]]);
      end
      exp_vec = acc;
      exp_v = (acc != 0);
    end else begin
      exp_vec = 0;
      exp_v = 1'b0;
    end
    chk(hit_vec == 16'(exp_vec), tag, int'(hit_vec), exp_vec);
    chk(hit_valid == exp_v, tag, int'(hit_valid), int'(exp_v));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sym_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(hit_vec == 16'd0, "R1 vec", int'(hit_vec), 0);
    chk(hit_valid == 1'b0, "R1 valid", int'(hit_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < 4; t++) st[t] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 64; s++) begin
        for (int v = 0; v < 4; v++) nxt[t][s][v] = (s*5 + v*17 + t*11 + 1) % 64;
        ix[t][s] = (s*3 + t) % 16;
      end
      vec[t][0] = 0;
      for (int e = 1; e < 15; e++) vec[t][e] = 16'hFFFF ^ (1 << ((e + t) % 16));
      vec[t][15] = 16'hFFFF;
      st[t] = 0;
    end

    do_reset();  // R1 out of reset

    // R7: load every table through the configuration port
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 64; s++) begin
        for (int v = 0; v < 4; v++) cfg_write(0, t, s*4 + v, nxt[t][s][v]);
        cfg_write(1, t, s, ix[t][s]);
      end
      for (int e = 1; e < 16; e++) cfg_write(2, t, e, vec[t][e]);
      cfg_write(2, t, 0, 16'hFFFF);  // R4: entry 0 write is ignored
    end
    // R7: select value 3 writes nothing
    for (int t = 0; t < 4; t++) cfg_write(3, t, t*8, 16'h0003);

    send(0, 0, "R6 idle");
    send(0, 8'hA5, "R6 idle");

    // R2/R3/R5: random stream with idle gaps
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 5) == 0) send(0, 0, "R6 gap");
      else send(1, int'($urandom % 256), "R3 stream");
    end
    for (int i = 0; i < 20; i++) send(1, 8'h00, "R2 repeat");
    for (int i = 0; i < 20; i++) send(1, 8'hFF, "R2 repeat");
    for (int i = 0; i < 40; i++) send(1, (i % 4) << (2 * (i % 4)), "R2 slice");

    // R3: all tiles enter an all-ones state
    do_reset();
    for (int t = 0; t < 4; t++) begin
      ix[t][nxt[t][0][0]] = 15;
      cfg_write(1, t, nxt[t][0][0], 15);
    end
    send(1, 8'h00, "R3 directed");
    chk(hit_vec == 16'hFFFF, "R3 all ones", int'(hit_vec), 16'hFFFF);
    chk(hit_valid == 1'b1, "R5 valid set", int'(hit_valid), 1);

    // R4: one tile at index 0 empties the result despite entry 0 written
    do_reset();
    ix[0][nxt[0][0][0]] = 0;
    cfg_write(1, 0, nxt[0][0][0], 0);
    send(1, 8'h00, "R4 directed");
    chk(hit_vec == 16'h0000, "R4 zero", int'(hit_vec), 0);
    chk(hit_valid == 1'b0, "R4 valid", int'(hit_valid), 0);

    // R6: state holds over idle cycles; R1: restart from state 0
    send(1, 8'h1B, "R6 pre");
    repeat (3) send(0, 8'h77, "R6 hold");
    send(1, 8'hE4, "R6 post");
    do_reset();
    for (int i = 0; i < 60; i++) send(1, int'($urandom % 256), "R1 restart");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule